// File: doc/BRIEF.md
# Memory Link Error Response Controller

This block decides how a memory buffer on a serial point-to-point channel reacts when the channel goes wrong. Each clock cycle is one southbound frame slot. For every valid frame the block receives the result of an external CRC check, a flag that marks the frame as a sync frame, and a flag that marks it as a soft channel reset command. Configuration inputs supply a fail-over flag, an error enable mask, a sync training interval and an alert start delay. The block returns a combinational command-execute gate for the current frame. It also produces a raw-frame capture strobe and register, first-error and next-error log registers, a sticky alert status bit, a DRAM self-refresh request and a northbound alert-pattern select.

There are two escalation levels. A CRC fault locks the command path until a good soft channel reset frame arrives. A loss of sync means the host has hung. That fault puts the DRAM into self-refresh and locks everything, including soft reset, until a link reset arrives. After either fault the northbound side sends the alert pattern in every frame, starting a programmable number of frames after the faulting frame.

The frame input has only a valid qualifier and no ready. The channel cannot stall, so every valid frame is consumed in its own cycle and the block never applies back-pressure. All other pins are plain level or pulse signals.

Top module: `link_fault_ctl`

## Requirements
- R1: In normal operation, a valid frame with `sb_crc_ok`=1 raises `cmd_exec` combinationally in the same cycle. `cmd_exec` is always 0 when `sb_vld`=0 or `link_rst`=1.
- R2: A CRC failure in normal operation with `err_en[0]`=1 keeps `cmd_exec` low for that frame. After that clock edge, `cap_stb` is high for one cycle, `cap_frame` holds the frame and `alert_sts` is 1. The error type is an error bit: bit 0 for a command-only frame (`sb_wide`=0) checked with the 14-bit CRC; bit 1 for a data or extra-command frame (`sb_wide`=1) checked with the 22-bit CRC; bit 2 for either frame kind while `failover`=1 (10-bit CRC).
- R3: With the matching enable bit clear (`err_en[0]` for CRC, `err_en[1]` for sync loss), the error is ignored. The frame executes, nothing is captured or logged, no alert is sent and no self-refresh is requested. A masked sync loss restarts the sync window.
- R4: `ferr` takes the error bits of the first error after reset or a `log_clr`. Later errors OR their bits into `nerr`, and `ferr` holds. `log_clr` zeroes `ferr`, `nerr` and `alert_sts`. An error in the same cycle as `log_clr` goes into the cleared `ferr`.
- R5: After a CRC error, only a valid frame with `sb_srst`=1 and a good CRC executes. That frame returns the block to normal and `nb_alert` falls after that edge. All other frames are ignored and raise no further CRC errors.
- R6: `nb_alert` rises `alert_dly` clock edges after the edge that samples the faulting frame; with `alert_dly`=0 it rises at that edge. It stays high until the clearing reset.
- R7: A sync loss is raised on the valid non-sync frame that completes 2×`sync_intv` consecutive valid non-sync frames. `sync_intv`=0 disables the check. The check runs in normal and CRC-locked states. With `err_en[1]`=1 that frame does not execute, its capture and log use error bit 3, and `sr_req` rises after that edge.
- R8: After a sync loss every frame is ignored, soft reset included. `nb_alert` and `sr_req` stay high and no further errors are logged.
- R9: `link_rst` returns the block to normal after that edge. It drops `nb_alert` and `sr_req` and restarts the sync window. It discards the frame in its cycle and keeps `ferr`, `nerr`, `alert_sts` and `cap_frame`.
- R10: A CRC error never raises `sr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one frame slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_vld | input | 1 | Southbound frame present in this slot |
| sb_frame | input | FRAME_W (120) | Raw southbound frame bits |
| sb_crc_ok | input | 1 | External CRC check passed for this frame |
| sb_wide | input | 1 | Frame carries write data or extra commands (22-bit CRC class) |
| sb_sync | input | 1 | Frame is a sync frame |
| sb_srst | input | 1 | Frame holds a soft channel reset command |
| failover | input | 1 | Channel runs in fail-over mode (10-bit CRC) |
| err_en | input | 2 | Error enables: bit 0 CRC, bit 1 sync loss |
| sync_intv | input | SYNC_W (8) | Sync training interval in frames |
| alert_dly | input | DLY_W (4) | Edges from fault to first alert frame |
| link_rst | input | 1 | Link reset indication |
| log_clr | input | 1 | Clear of logs and sticky status |
| cmd_exec | output | 1 | Execute the command of this frame |
| cap_stb | output | 1 | One-cycle pulse: a frame was captured |
| cap_frame | output | FRAME_W (120) | Captured raw frame |
| ferr | output | 4 | First error type |
| nerr | output | 4 | Accumulated later error types |
| alert_sts | output | 1 | Sticky alert status |
| sr_req | output | 1 | DRAM self-refresh request |
| nb_alert | output | 1 | Select alert pattern on northbound frames |

## Verification
The checker watches, on every cycle, the rules that hold between outputs: no execution while self-refresh is requested, a capture only after a frame that did not execute, sticky status and first-error stability, self-refresh persisting until link reset, and both lock outputs dropping after it. Only the bench scenarios can show the timed and ordered behaviour. That covers the alert start delay, the exact frame that completes a sync window, the rule that a soft reset clears a CRC lock but not a hang, and the masking that turns an error into normal execution.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    LS_RUN      = 2'd0,
    LS_CRC_HOLD = 2'd1,
    LS_HANG     = 2'd2
  } lnk_state_e;

  localparam int ERR_W     = 4;
  localparam int EB_CMD    = 0;
  localparam int EB_DATA   = 1;
  localparam int EB_SHORT  = 2;
  localparam int EB_SYNC   = 3;
  localparam int EN_W      = 2;
  localparam int EN_CRC    = 0;
  localparam int EN_SYNC   = 1;
endpackage

// File: rtl/lfc_sync_mon.sv
module lfc_sync_mon #(
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic              frm_sync,
  input  logic              active,
  input  logic              flush,
  input  logic [SYNC_W-1:0] intv,
  output logic              miss
);
  localparam int CNT_W = SYNC_W + 1;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {intv, 1'b0} - CNT_W'(1);
  assign miss  = active && !flush && frm_vld && !frm_sync &&
                 (intv != '0) && (run_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (flush) begin
      run_cnt <= '0;
    end else if (frm_vld && active) begin
      if (frm_sync || miss) run_cnt <= '0;
      else                  run_cnt <= run_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lfc_alert_seq.sv
module lfc_alert_seq
  import lfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_rst,
  input  logic             crc_ev,
  input  logic             loss_ev,
  input  logic             srst_ok,
  input  logic [DLY_W-1:0] dly,
  output lnk_state_e       state,
  output logic             nb_alert,
  output logic             sr_req
);
  logic [DLY_W-1:0] wait_cnt;
  logic             leave_hold;
  logic             enter_lock;

  assign leave_hold = (state == LS_CRC_HOLD) && srst_ok && !loss_ev;
  assign enter_lock = (state == LS_RUN) && (crc_ev || loss_ev);
  assign nb_alert   = (state != LS_RUN) && (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LS_RUN;
    end else if (link_rst) begin
      state <= LS_RUN;
    end else if (loss_ev) begin
      state <= LS_HANG;
    end else if (state == LS_RUN && crc_ev) begin
      state <= LS_CRC_HOLD;
    end else if (leave_hold) begin
      state <= LS_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (link_rst) begin
      wait_cnt <= '0;
    end else if (enter_lock) begin
      wait_cnt <= dly;
    end else if (leave_hold) begin
      wait_cnt <= '0;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_req <= 1'b0;
    else if (link_rst) sr_req <= 1'b0;
    else if (loss_ev)  sr_req <= 1'b1;
  end
endmodule

// File: rtl/lfc_err_log.sv
module lfc_err_log
  import lfc_pkg::*;
#(
  parameter int FRAME_W = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ERR_W-1:0]   ev,
  input  logic [FRAME_W-1:0] frame,
  input  logic               clr,
  output logic [ERR_W-1:0]   ferr,
  output logic [ERR_W-1:0]   nerr,
  output logic               sts,
  output logic               cap_stb,
  output logic [FRAME_W-1:0] cap_frame
);
  logic             any_ev;
  logic [ERR_W-1:0] ferr_base;
  logic [ERR_W-1:0] nerr_base;

  assign any_ev    = |ev;
  assign ferr_base = clr ? '0 : ferr;
  assign nerr_base = clr ? '0 : nerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr <= '0;
      nerr <= '0;
      sts  <= 1'b0;
    end else begin
      if (any_ev && ferr_base == '0) begin
        ferr <= ev;
        nerr <= nerr_base;
      end else begin
        ferr <= ferr_base;
        nerr <= nerr_base | ev;
      end
      sts <= any_ev ? 1'b1 : (clr ? 1'b0 : sts);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_stb   <= 1'b0;
      cap_frame <= '0;
    end else begin
      cap_stb <= any_ev;
      if (any_ev) cap_frame <= frame;
    end
  end
endmodule

// File: rtl/link_fault_ctl.sv
module link_fault_ctl
  import lfc_pkg::*;
#(
  parameter int FRAME_W = 120,
  parameter int SYNC_W  = 8,
  parameter int DLY_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sb_vld,
  input  logic [FRAME_W-1:0] sb_frame,
  input  logic               sb_crc_ok,
  input  logic               sb_wide,
  input  logic               sb_sync,
  input  logic               sb_srst,
  input  logic               failover,
  input  logic [1:0]         err_en,
  input  logic [SYNC_W-1:0]  sync_intv,
  input  logic [DLY_W-1:0]   alert_dly,
  input  logic               link_rst,
  input  logic               log_clr,
  output logic               cmd_exec,
  output logic               cap_stb,
  output logic [FRAME_W-1:0] cap_frame,
  output logic [3:0]         ferr,
  output logic [3:0]         nerr,
  output logic               alert_sts,
  output logic               sr_req,
  output logic               nb_alert
);
  lnk_state_e       state;
  logic             miss;
  logic             crc_ev;
  logic             loss_ev;
  logic             srst_ok;
  logic             mon_active;
  logic [ERR_W-1:0] ev;

  assign srst_ok    = sb_vld && sb_crc_ok && sb_srst;
  assign mon_active = (state != LS_HANG);
  assign crc_ev     = sb_vld && !sb_crc_ok && (state == LS_RUN) &&
                      err_en[EN_CRC] && !link_rst;
  assign loss_ev    = miss && err_en[EN_SYNC];

  always_comb begin
    ev           = '0;
    ev[EB_CMD]   = crc_ev && !failover && !sb_wide;
    ev[EB_DATA]  = crc_ev && !failover && sb_wide;
    ev[EB_SHORT] = crc_ev && failover;
    ev[EB_SYNC]  = loss_ev;
  end

  always_comb begin
    cmd_exec = 1'b0;
    if (sb_vld && !link_rst && !crc_ev && !loss_ev) begin
      unique case (state)
        LS_RUN:      cmd_exec = 1'b1;
        LS_CRC_HOLD: cmd_exec = srst_ok;
        default:     cmd_exec = 1'b0;
      endcase
    end
  end

  lfc_sync_mon #(.SYNC_W(SYNC_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_vld  (sb_vld),
    .frm_sync (sb_sync),
    .active   (mon_active),
    .flush    (link_rst),
    .intv     (sync_intv),
    .miss     (miss)
  );

  lfc_alert_seq #(.DLY_W(DLY_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_rst (link_rst),
    .crc_ev   (crc_ev),
    .loss_ev  (loss_ev),
    .srst_ok  (srst_ok),
    .dly      (alert_dly),
    .state    (state),
    .nb_alert (nb_alert),
    .sr_req   (sr_req)
  );

  lfc_err_log #(.FRAME_W(FRAME_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .frame     (sb_frame),
    .clr       (log_clr),
    .ferr      (ferr),
    .nerr      (nerr),
    .sts       (alert_sts),
    .cap_stb   (cap_stb),
    .cap_frame (cap_frame)
  );
endmodule

// File: rtl/lfc_chk.sv
module lfc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sb_vld,
  input logic       link_rst,
  input logic       log_clr,
  input logic       cmd_exec,
  input logic       cap_stb,
  input logic [3:0] ferr,
  input logic       alert_sts,
  input logic       sr_req,
  input logic       nb_alert
);
  AST_HANG_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req |-> !cmd_exec);                                              // R8
  AST_CAP_AFTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> $past(sb_vld && !cmd_exec));                            // R2
  AST_CAP_WITH_STS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> alert_sts);                                             // R2
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_sts && !log_clr) |=> alert_sts);                             // R4
  AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr != 4'd0 && !log_clr) |=> $stable(ferr));                      // R4
  AST_SR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_req && !link_rst) |=> sr_req);                                  // R8
  AST_LINK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> (!sr_req && !nb_alert));                               // R9
  AST_NO_EXEC_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |-> !cmd_exec);                                            // R1
endmodule

bind link_fault_ctl lfc_chk u_lfc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sb_vld    (sb_vld),
  .link_rst  (link_rst),
  .log_clr   (log_clr),
  .cmd_exec  (cmd_exec),
  .cap_stb   (cap_stb),
  .ferr      (ferr),
  .alert_sts (alert_sts),
  .sr_req    (sr_req),
  .nb_alert  (nb_alert)
);

// File: tb/link_fault_ctl_test.sv
module link_fault_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 120;
  localparam int SW = 8;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sb_vld = 0, sb_crc_ok = 1, sb_wide = 0, sb_sync = 0, sb_srst = 0;
  logic [FW-1:0] sb_frame = '0;
  logic failover = 0;
  logic [1:0] err_en = 2'b11;
  logic [SW-1:0] sync_intv = '0;
  logic [DW-1:0] alert_dly = '0;
  logic link_rst = 0, log_clr = 0;
  logic cmd_exec, cap_stb, alert_sts, sr_req, nb_alert;
  logic [FW-1:0] cap_frame;
  logic [3:0] ferr, nerr;

  int checks = 0;
  int errors = 0;

  // bench model
  int m_st = 0;
  int m_sync = 0;
  int m_wait = 0;
  logic [3:0] m_ferr = 0, m_nerr = 0;
  logic m_sts = 0, m_sr = 0, m_cap = 0;
  logic [FW-1:0] m_capf = '0;
  logic e_hit, e_crc, e_loss, e_exec;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_fault_ctl uut (
    .clk(clk), .rst_n(rst_n), .sb_vld(sb_vld), .sb_frame(sb_frame),
    .sb_crc_ok(sb_crc_ok), .sb_wide(sb_wide), .sb_sync(sb_sync),
    .sb_srst(sb_srst), .failover(failover), .err_en(err_en),
    .sync_intv(sync_intv), .alert_dly(alert_dly), .link_rst(link_rst),
    .log_clr(log_clr), .cmd_exec(cmd_exec), .cap_stb(cap_stb),
    .cap_frame(cap_frame), .ferr(ferr), .nerr(nerr), .alert_sts(alert_sts),
    .sr_req(sr_req), .nb_alert(nb_alert)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_alert();
    return (m_st != 0) && (m_wait == 0);
  endfunction

  task automatic m_eval();
    e_hit  = (m_st != 2) && !link_rst && sb_vld && !sb_sync &&
             (sync_intv != 0) && (m_sync == 2*int'(sync_intv) - 1);
    e_loss = e_hit && err_en[1];
    e_crc  = sb_vld && !sb_crc_ok && (m_st == 0) && err_en[0] && !link_rst;
    e_exec = sb_vld && !link_rst && !e_crc && !e_loss &&
             ((m_st == 0) || (m_st == 1 && sb_crc_ok && sb_srst));
  endtask

  task automatic m_update();
    logic [3:0] ev;
    logic leave;
    ev = {e_loss, e_crc && failover, e_crc && !failover && sb_wide,
          e_crc && !failover && !sb_wide};
    leave = (m_st == 1) && sb_vld && sb_crc_ok && sb_srst && !e_loss;
    m_cap = |ev;
    if (|ev) m_capf = sb_frame;
    if (log_clr) begin m_ferr = 0; m_nerr = 0; m_sts = 0; end
    if (|ev) begin
      if (m_ferr == 0) m_ferr = ev; else m_nerr = m_nerr | ev;
      m_sts = 1;
    end
    if (link_rst) m_sync = 0;
    else if (sb_vld && m_st != 2) m_sync = (sb_sync || e_hit) ? 0 : m_sync + 1;
    if (link_rst) m_wait = 0;
    else if (m_st == 0 && (e_crc || e_loss)) m_wait = int'(alert_dly);
    else if (leave) m_wait = 0;
    else if (m_wait != 0) m_wait--;
    if (link_rst) m_sr = 0; else if (e_loss) m_sr = 1;
    if (link_rst) m_st = 0;
    else if (e_loss) m_st = 2;
    else if (m_st == 0 && e_crc) m_st = 1;
    else if (leave) m_st = 0;
  endtask

  // one frame slot: inputs already applied at a falling edge
  task automatic tick();
    #1;
    m_eval();
    chk(cmd_exec === e_exec, "R1 cmd_exec", 128'(cmd_exec), 128'(e_exec));
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk(cap_stb === m_cap, "R2 cap_stb", 128'(cap_stb), 128'(m_cap));
    chk(cap_frame === m_capf, "R2 cap_frame", 128'(cap_frame), 128'(m_capf));
    chk(alert_sts === m_sts, "R2 alert_sts", 128'(alert_sts), 128'(m_sts));
    chk(ferr === m_ferr, "R4 ferr", 128'(ferr), 128'(m_ferr));
    chk(nerr === m_nerr, "R4 nerr", 128'(nerr), 128'(m_nerr));
    chk(sr_req === m_sr, "R7 sr_req", 128'(sr_req), 128'(m_sr));
    chk(nb_alert === m_alert(), "R6 nb_alert", 128'(nb_alert), 128'(m_alert()));
  endtask

  task automatic put(input logic v, input logic ok, input logic w,
                     input logic s, input logic r);
    sb_vld = v; sb_crc_ok = ok; sb_wide = w; sb_sync = s; sb_srst = r;
    sb_frame = {$urandom, $urandom, $urandom, $urandom};
    link_rst = 0; log_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk({cmd_exec, cap_stb, alert_sts, sr_req, nb_alert, ferr, nerr} === '0,
        "R9 reset state", 128'(ferr), 128'(0));

    // R2 / R6 / R10: command CRC error with delay 2
    alert_dly = 2; sync_intv = 0; err_en = 2'b11;
    put(1, 1, 0, 0, 0); tick();
    put(1, 0, 0, 0, 0); tick();
    chk(ferr === 4'b0001, "R2 command CRC type", 128'(ferr), 128'(1));
    chk(nb_alert === 0 && sr_req === 0, "R10 no self-refresh on CRC",
        128'(sr_req), 128'(0));
    put(0, 1, 0, 0, 0); tick();
    chk(nb_alert === 0, "R6 alert not yet", 128'(nb_alert), 128'(0));
    put(1, 1, 0, 0, 0); tick();
    chk(nb_alert === 1, "R6 alert after delay", 128'(nb_alert), 128'(1));
    // R5: lockout
    put(1, 0, 1, 0, 0); tick();
    chk(nerr === 0, "R5 no error while locked", 128'(nerr), 128'(0));
    put(1, 0, 0, 0, 1); tick();
    chk(nb_alert === 1, "R5 bad soft reset ignored", 128'(nb_alert), 128'(1));
    put(1, 1, 0, 0, 1); #1;
    chk(cmd_exec === 1, "R5 good soft reset executes", 128'(cmd_exec), 128'(1));
    tick();
    chk(nb_alert === 0, "R5 soft reset clears alert", 128'(nb_alert), 128'(0));
    // R4: second error in fail-over
    failover = 1;
    put(1, 0, 1, 0, 0); tick();
    chk(ferr === 4'b0001 && nerr === 4'b0100, "R4 next error accumulates",
        128'(nerr), 128'(4));
    put(1, 1, 0, 0, 1); tick();
    put(0, 1, 0, 0, 0); log_clr = 1; tick();
    chk(ferr === 0 && nerr === 0 && alert_sts === 0, "R4 log clear",
        128'(ferr), 128'(0));
    failover = 0;
    // R3: masked CRC
    err_en = 2'b10;
    put(1, 0, 0, 0, 0); #1;
    chk(cmd_exec === 1, "R3 masked CRC executes", 128'(cmd_exec), 128'(1));
    tick();
    chk(cap_stb === 0 && alert_sts === 0, "R3 masked CRC not logged",
        128'(cap_stb), 128'(0));
    // R7 / R8: sync loss with interval 2, no delay
    err_en = 2'b11; sync_intv = 2; alert_dly = 0;
    put(1, 1, 0, 1, 0); tick();
    for (int i = 0; i < 3; i++) begin put(1, 1, 0, 0, 0); tick(); end
    put(1, 1, 0, 0, 0); #1;
    chk(cmd_exec === 0, "R7 loss frame not executed", 128'(cmd_exec), 128'(0));
    tick();
    chk(sr_req === 1 && nb_alert === 1 && ferr === 4'b1000,
        "R7 sync loss escalation", 128'(ferr), 128'(8));
    put(1, 1, 0, 0, 1); #1;
    chk(cmd_exec === 0, "R8 soft reset ignored in hang", 128'(cmd_exec), 128'(0));
    tick();
    chk(sr_req === 1 && nb_alert === 1, "R8 hang persists", 128'(sr_req), 128'(1));
    // R9: link reset
    put(1, 1, 0, 0, 0); link_rst = 1; tick();
    chk(sr_req === 0 && nb_alert === 0 && ferr === 4'b1000,
        "R9 link reset keeps logs", 128'(ferr), 128'(8));
    // R3: masked sync loss
    err_en = 2'b01;
    for (int i = 0; i < 5; i++) begin put(1, 1, 0, 0, 0); tick(); end
    chk(sr_req === 0 && nb_alert === 0, "R3 masked sync loss", 128'(sr_req), 128'(0));

    // random segments, each started by a link reset
    for (int seg = 0; seg < 12; seg++) begin
      err_en = 2'($urandom_range(0, 3));
      sync_intv = SW'($urandom_range(0, 5));
      alert_dly = DW'($urandom_range(0, 4));
      failover = 1'($urandom_range(0, 1));
      put(0, 1, 0, 0, 0); link_rst = 1; tick();
      for (int c = 0; c < 300; c++) begin
        put($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 9,
            1'($urandom_range(0, 1)), $urandom_range(0, 9) < 1,
            $urandom_range(0, 9) < 1);
        link_rst = ($urandom_range(0, 199) == 0);
        log_clr = ($urandom_range(0, 49) == 0);
        tick();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule